// File: doc/BRIEF.md
# Serial Configuration Port for an Image-Sensor Front End

This block is the write-only configuration port of an image-sensor analog front end. It borrows three pins of the parallel output bus. While the line-start strobe is high, those pins carry a serial clock, a latch/shift-enable line and a data line. While the strobe is low, the pins return to output duty. Each write frame is nine bits long, sent most significant bit first: a 3-bit register address, then a 6-bit value. The frame commits when the latch line rises.

The port holds eight 6-bit registers:
- a sampler/color-mode register,
- three per-color offset registers,
- three per-color gain registers,
- a test/power-down register.

The register contents leave the block as one flat vector, together with a few decoded control fields. A one-cycle restart pulse tells the color sequencer that the mode register was rewritten. All pin inputs are asynchronous to the master clock. They pass through a synchronizer, and their edges are detected in the master clock domain.

Top module: `afe_cfg_port`

## Requirements
- R1: After reset, all eight registers read zero, every decoded field is zero and `mode_restart` is low.
- R2: A frame consists of nine data-pin bits, each sampled on a serial-clock rising edge while the latch is low and the strobe is high. The bits are an address (frame bits 8:6, sent first) followed by a value (frame bits 5:0, MSB first). When the latch rises, the value is written to the addressed register, and no other register changes.
- R3: When more than nine bits are shifted before the latch rises, only the last nine form the frame.
- R4: A latch rise with fewer than nine bits shifted since the previous latch rise writes nothing. Every latch rise restarts the bit count.
- R5: Serial-clock rising edges while the latch is high shift no bits.
- R6: While the strobe is low, shifting and latch rises are ignored and `bus_drive_en` is high. While the strobe is high, `bus_drive_en` is low.
- R7: A register changes only at a committed write, and only the addressed one.
- R8: `mode_restart` pulses high for exactly one cycle after each write to address 0. It stays low for writes to any other address.
- R9: `reg_flat[6n+5:6n]` holds register n. The decoded fields are:
  - `cds_disable` = register 0 bit 5
  - `sig_positive` = register 0 bit 4
  - `color_mode` = register 0 bits 2:0
  - `power_down` = register 7 bit 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| line_strobe | input | 1 | Line-start strobe; the serial port is active while it is high |
| ser_clk | input | 1 | Serial clock pin (shared with the output bus) |
| ser_latch | input | 1 | Latch/shift-enable pin (shared with the output bus) |
| ser_data | input | 1 | Serial data pin (shared with the output bus) |
| bus_drive_en | output | 1 | High when the shared pins should drive output data |
| reg_flat | output | 48 | All eight registers; register n occupies bits 6n+5:6n |
| cds_disable | output | 1 | Single-ended sampling select |
| sig_positive | output | 1 | Signal polarity select |
| color_mode | output | 3 | Color sequencing mode |
| power_down | output | 1 | Power-down request |
| mode_restart | output | 1 | One-cycle pulse after a write to register 0 |

## Verification
The checker watches three things on every cycle:
- that a commit lands the captured value in the captured address (R2);
- that the register vector changes only at a commit (R7) and never while the strobe is low (R6);
- that the restart pulse lasts one cycle and follows only a write to address 0 (R8).

The remaining behaviours depend on the order of bits arriving at the pins, so only the bench scenarios can show them: the nine-bit framing and MSB-first order, the use of the last nine bits in an over-long burst, the rejection of a short burst, and the suppression of shifting while the latch is high. The reset values and the decoded field positions are also checked by the bench.

// File: rtl/afe_cfg_pkg.sv
package afe_cfg_pkg;
   // bit positions inside the mode register
   localparam int CDS_BIT   = 5;
   localparam int POL_BIT   = 4;
   localparam int CMODE_LSB = 0;
   localparam int CMODE_W   = 3;
   // bit position inside the test/power register
   localparam int PD_BIT    = 0;
   // minimum register width that holds all decoded fields
   localparam int MIN_DATA_W = 6;

   function automatic int frame_bits(int aw, int dw);
      return aw + dw;
   endfunction
endpackage

// File: rtl/afe_cfg_sync.sv
module afe_cfg_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("afe_cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/afe_cfg_edge.sv
module afe_cfg_edge #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/afe_cfg_shift.sv
module afe_cfg_shift #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_in,
   input  logic               clear,
   output logic [FRAME_W-1:0] frame,
   output logic               full
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
         cnt   <= '0;
      end else if (clear) begin
         cnt   <= '0;
      end else if (shift_en) begin
         frame <= {frame[FRAME_W-2:0], bit_in};
         if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/afe_cfg_regbank.sv
module afe_cfg_regbank #(
   parameter int DATA_W   = 6,
   parameter int ADDR_W   = 3,
   parameter int MODE_IDX = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [(1<<ADDR_W)*DATA_W-1:0] reg_flat,
   output logic                          mode_restart
);
   localparam int NREG = 1 << ADDR_W;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= '0;
         else if (wr_en && wr_addr == ADDR_W'(r))     q <= wr_data;
      end
      assign reg_flat[r*DATA_W +: DATA_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_restart <= 1'b0;
      else        mode_restart <= wr_en && (wr_addr == ADDR_W'(MODE_IDX));
   end
endmodule

// File: rtl/afe_cfg_port.sv
module afe_cfg_port #(
   parameter int DATA_W      = 6,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NREG       = 1 << ADDR_W,
   localparam int FLAT_W     = NREG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic              ser_clk,
   input  logic              ser_latch,
   input  logic              ser_data,
   output logic              bus_drive_en,
   output logic [FLAT_W-1:0] reg_flat,
   output logic              cds_disable,
   output logic              sig_positive,
   output logic [2:0]        color_mode,
   output logic              power_down,
   output logic              mode_restart
);
   import afe_cfg_pkg::*;

   localparam int FRAME_W  = frame_bits(ADDR_W, DATA_W);
   localparam int MODE_IDX = 0;
   localparam int PD_IDX   = NREG - 1;

   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("afe_cfg_port: DATA_W too small for the decoded fields");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("afe_cfg_port: ADDR_W must be at least 1");
   end

   logic strobe_q, sclk_q, latch_q, data_q;
   logic sclk_rise, latch_rise;
   logic shift_en, latch_evt, full;
   logic [FRAME_W-1:0] frame;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   afe_cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({line_strobe, ser_clk, ser_latch, ser_data}),
      .q({strobe_q, sclk_q, latch_q, data_q})
   );

   afe_cfg_edge #(.WIDTH(2)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .lvl({sclk_q, latch_q}),
      .rise({sclk_rise, latch_rise})
   );

   // pin-sharing qualification: serial port only while strobe high
   assign shift_en  = strobe_q & sclk_rise & ~latch_q;
   assign latch_evt = strobe_q & latch_rise;

   afe_cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .shift_en(shift_en), .bit_in(data_q), .clear(latch_evt),
      .frame(frame), .full(full)
   );

   assign wr_en   = latch_evt & full;
   assign wr_addr = frame[FRAME_W-1 -: ADDR_W];
   assign wr_data = frame[DATA_W-1:0];

   afe_cfg_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .reg_flat(reg_flat), .mode_restart(mode_restart)
   );

   assign bus_drive_en = ~strobe_q;
   assign cds_disable  = reg_flat[MODE_IDX*DATA_W + CDS_BIT];
   assign sig_positive = reg_flat[MODE_IDX*DATA_W + POL_BIT];
   assign color_mode   = reg_flat[MODE_IDX*DATA_W + CMODE_LSB +: CMODE_W];
   assign power_down   = reg_flat[PD_IDX*DATA_W + PD_BIT];
endmodule

// File: rtl/afe_cfg_port_chk.sv
module afe_cfg_port_chk #(
   parameter int DATA_W = 6,
   parameter int ADDR_W = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          strobe_q,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             wr_addr,
   input logic [DATA_W-1:0]             wr_data,
   input logic [(1<<ADDR_W)*DATA_W-1:0] reg_flat,
   input logic                          mode_restart
);
   // R2
   wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> reg_flat[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_q |=> $stable(reg_flat));

   // R7
   change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_flat) |-> $past(wr_en));

   // R8
   restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_restart |=> !mode_restart);

   // R8
   restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_restart |-> $past(wr_en && wr_addr == '0));
endmodule

bind afe_cfg_port afe_cfg_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe_q(strobe_q), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .reg_flat(reg_flat),
   .mode_restart(mode_restart)
);

// File: tb/afe_cfg_port_tb.sv
module afe_cfg_port_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_strobe = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0, ser_data = 1'b0;
   logic        bus_drive_en, cds_disable, sig_positive, power_down, mode_restart;
   logic [47:0] reg_flat;
   logic [2:0]  color_mode;

   int checks = 0, fails = 0, pulses = 0;
   bit done = 0;
   logic [5:0] exp_r [8];

   always #2 clk = ~clk;

   afe_cfg_port u_dut (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .ser_clk(ser_clk),
      .ser_latch(ser_latch), .ser_data(ser_data), .bus_drive_en(bus_drive_en),
      .reg_flat(reg_flat), .cds_disable(cds_disable), .sig_positive(sig_positive),
      .color_mode(color_mode), .power_down(power_down), .mode_restart(mode_restart)
   );

   always @(negedge clk) if (mode_restart) pulses++;

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      for (int i = 0; i < 8; i++) chk(req, 32'(reg_flat[i*6 +: 6]), 32'(exp_r[i]));
   endtask

   task automatic send_bit(logic b);
      ser_data = b; tick(3);
      ser_clk = 1'b1; tick(3);
      ser_clk = 1'b0; tick(3);
   endtask

   task automatic send_frame(logic [2:0] a, logic [5:0] d);
      logic [8:0] f = {a, d};
      for (int i = 8; i >= 0; i--) send_bit(f[i]);
   endtask

   task automatic latch_pulse();
      ser_latch = 1'b1; tick(3);
      for (int i = 0; i < 3; i++) begin
         ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
      end
      ser_latch = 1'b0; tick(4);
   endtask

   task automatic t_reset();
      chk_all("R1 reset");
      chk("R1 restart", 32'(mode_restart), 0);
      chk("R1 fields", 32'({cds_disable, sig_positive, color_mode, power_down}), 0);
      chk("R6 drive while strobe low", 32'(bus_drive_en), 1);
   endtask

   task automatic t_all_addrs();
      line_strobe = 1'b1; tick(4);
      chk("R6 released while strobe high", 32'(bus_drive_en), 0);
      for (int a = 1; a < 8; a++) begin
         logic [5:0] v = 6'(a * 9 + 3);
         send_frame(3'(a), v); latch_pulse();
         exp_r[a] = v;
         chk_all("R2 R7 write per address");
      end
   endtask

   task automatic t_fields();
      pulses = 0;
      send_frame(3'd0, 6'b10_0101); latch_pulse(); exp_r[0] = 6'b10_0101;
      chk("R8 restart on reg0", 32'(pulses), 1);
      chk("R9 cds", 32'(cds_disable), 1);
      chk("R9 pol", 32'(sig_positive), 0);
      chk("R9 cmode", 32'(color_mode), 5);
      chk("R9 pd", 32'(power_down), 32'(exp_r[7][0]));
      send_frame(3'd0, 6'b01_1010); latch_pulse(); exp_r[0] = 6'b01_1010;
      chk("R9 pol", 32'(sig_positive), 1);
      chk("R9 cmode", 32'(color_mode), 2);
      pulses = 0;
      send_frame(3'd7, 6'b00_0001); latch_pulse(); exp_r[7] = 6'h01;
      chk("R9 pd", 32'(power_down), 1);
      chk("R8 no restart other addr", 32'(pulses), 0);
      chk_all("R9 flat");
   endtask

   task automatic t_long_burst();
      send_bit(1); send_bit(0); send_bit(1); send_bit(1);
      send_frame(3'd2, 6'h2D); latch_pulse(); exp_r[2] = 6'h2D;
      chk_all("R3 last nine bits");
   endtask

   task automatic t_short_burst();
      send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(1);
      latch_pulse();
      chk_all("R4 short burst ignored");
      send_bit(0); send_bit(1); send_bit(0); send_bit(1);
      latch_pulse();
      chk_all("R4 count restarts");
      send_frame(3'd4, 6'h15); latch_pulse(); exp_r[4] = 6'h15;
      chk_all("R4 full frame after short");
   endtask

   task automatic t_latch_high();
      logic [8:0] g = {3'd6, 6'h3C};
      send_frame(3'd5, 6'h07);
      ser_latch = 1'b1; tick(4);
      exp_r[5] = 6'h07;
      for (int i = 8; i >= 0; i--) send_bit(g[i]);
      ser_latch = 1'b0; tick(4);
      latch_pulse();
      chk_all("R5 no shift while latch high");
   endtask

   task automatic t_strobe_low();
      line_strobe = 1'b0; tick(4);
      chk("R6 drive", 32'(bus_drive_en), 1);
      send_frame(3'd1, 6'h3F); latch_pulse();
      chk_all("R6 ignored while strobe low");
      line_strobe = 1'b1; tick(4);
      latch_pulse();
      chk_all("R6 bits while low not counted");
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_r[i] = '0;
      tick(3);
      t_reset();
      rst_n = 1'b1; tick(3);
      t_reset();
      t_all_addrs();
      t_fields();
      t_long_burst();
      t_short_burst();
      t_latch_high();
      t_strobe_low();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule